// File: doc/BRIEF.md
# Rate-Half Convolutional Bit Encoder

The encoder takes a serial stream of data bits and produces two code bits for each one. It keeps a two-bit memory of the most recent input bits, so it has four states. Each output pair depends on the current input bit and on that memory, which makes the encoder a Mealy machine. The memory is cleared by reset, so every stream starts from the all-zero state.

The parameter `SERIAL` selects one of two output variants. With `SERIAL = 0`, the whole code pair is registered and appears on `code_o` one cycle after the input bit is taken. With `SERIAL = 1`, the pair is sent one bit per cycle on `code_o[0]`. The state memory can then advance at most every second output cycle, so it runs at half the output bit rate.

Top module: `conv_enc`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `code_valid_o` is 0 and `ready_o` is 1 in both variants. The state memory holds 00, so input 1 gives pair 11 and input 0 gives pair 00.
- R2: The first code bit is the XOR of the input bit, the newer stored bit and the older stored bit. In the parallel variant it is carried on `code_o[1]`.
- R3: The second code bit is the XOR of the input bit and the older stored bit. In the parallel variant it is carried on `code_o[0]`.
- R4: An input bit is accepted when `bit_valid_i` and `ready_o` are both high. On acceptance, the newer stored bit takes the input bit and the older stored bit takes the previous newer bit.
- R5: When no input bit is accepted, the state memory does not change. In the parallel variant, `code_valid_o` is also low in the next cycle.
- R6: In the parallel variant, `ready_o` is always 1. The pair for an accepted bit is on `code_o` with `code_valid_o` high in the cycle after acceptance.
- R7: In the serial variant, the cycle after acceptance shows the first code bit on `code_o[0]`. The cycle after that shows the second code bit. `code_valid_o` is high in both cycles and `code_o[1]` is 0.
- R8: In the serial variant, `ready_o` is low in the cycle after each acceptance. An input bit offered in that cycle is ignored and does not change the state memory.
- R9: Starting from reset, the inputs 1,1,0,1,0,0,1,0 (first bit first) produce the pairs 11 01 01 00 10 11 11 10, with the first code bit written on the left.
- R10: Asserting reset in the middle of a stream returns the state memory to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Data bit to encode |
| bit_valid_i | input | 1 | Data bit is offered |
| ready_o | output | 1 | Encoder can take a bit this cycle |
| code_o | output | 2 | Code pair {first, second}; in the serial variant, the current code bit is on bit 0 |
| code_valid_o | output | 1 | `code_o` carries valid code |

## Verification
The bench targets the paths through the state memory where a mistake hides in a single case:
- **Swapped tap or wrong shift direction.** Bits are driven from states 01, 10 and 11, where such an error corrupts only some pairs.
- **Lost memory.** Reset is pulsed from state 11. An encoder that kept its memory would give pair 10 instead of 11.
- **Idle gaps.** The bench inserts gaps in which `bit_i` toggles. An encoder that shifted on idle cycles would emit the wrong next pair.
- **Serial hold-off cycle.** The serial instance is offered a flipped bit in the cycle after each acceptance. A serializer that took that bit would corrupt the state and every later pair. A serializer that swapped the order would put the second code bit first.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int unsigned MEM_W  = 2;
  localparam int unsigned CODE_W = 2;

  typedef logic [MEM_W-1:0] state_t;  // [MEM_W-1] newest, [0] oldest

  typedef struct packed {
    logic first;
    logic second;
  } pair_t;

  function automatic pair_t code_map(input logic x, input state_t s);
    pair_t p;
    p.first  = x ^ (^s);
    p.second = x ^ s[0];
    return p;
  endfunction
endpackage

// File: rtl/conv_state_reg.sv
module conv_state_reg
  import conv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_i,
  input  logic   bit_i,
  output state_t state_o
);
  state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (adv_i) state_q <= {bit_i, state_q[MEM_W-1:1]};
  end

  assign state_o = state_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (state_q[MEM_W-1] == $past(bit_i)) && (state_q[0] == $past(state_q[1]))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q)); // R5
endmodule

// File: rtl/conv_par_out.sv
module conv_par_out
  import conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  pair_t             pair_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  pair_t pair_q;
  logic  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept_i;
      if (accept_i) pair_q <= pair_i;
    end
  end

  assign code_o  = {pair_q.first, pair_q.second};
  assign valid_o = valid_q;

  AST_PAR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> valid_o && (code_o == $past({pair_i.first, pair_i.second}))); // R6

  AST_PAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !valid_o); // R5
endmodule

// File: rtl/conv_serializer.sv
module conv_serializer
  import conv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  pair_t pair_i,
  output logic  bit_o,
  output logic  valid_o,
  output logic  ready_o
);
  logic pend_q;   // second bit still owed
  logic hold_q;
  logic bit_q;
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (pend_q) begin
      bit_q   <= hold_q;
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (accept_i) begin
      bit_q   <= pair_i.first;
      hold_q  <= pair_i.second;
      valid_q <= 1'b1;
      pend_q  <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign ready_o = !pend_q;

  AST_SER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> valid_o && !ready_o && (bit_o == $past(pair_i.first))); // R7

  AST_SER_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> ##1 valid_o && (bit_o == $past(pair_i.second, 2))); // R7

  AST_SER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o); // R8
endmodule

// File: rtl/conv_enc.sv
module conv_enc
  import conv_pkg::*;
#(
  parameter bit SERIAL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_valid_i,
  output logic       ready_o,
  output logic [1:0] code_o,
  output logic       code_valid_o
);
  state_t state;
  pair_t  pair;
  logic   accept;
  logic   rdy;

  assign accept  = bit_valid_i && rdy;
  assign pair    = code_map(bit_i, state);
  assign ready_o = rdy;

  conv_state_reg u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .bit_i  (bit_i),
    .state_o(state)
  );

  generate
    if (SERIAL) begin : g_ser
      logic ser_bit;
      logic ser_valid;
      conv_serializer u_ser (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .accept_i(accept),
        .pair_i (pair),
        .bit_o  (ser_bit),
        .valid_o(ser_valid),
        .ready_o(rdy)
      );
      assign code_o       = {1'b0, ser_bit};
      assign code_valid_o = ser_valid;

      AST_SER_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_valid_o |-> !code_o[1]); // R7
    end else begin : g_par
      logic [CODE_W-1:0] par_code;
      logic              par_valid;
      conv_par_out u_par (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .accept_i(accept),
        .pair_i (pair),
        .code_o (par_code),
        .valid_o(par_valid)
      );
      assign rdy          = 1'b1;
      assign code_o       = par_code;
      assign code_valid_o = par_valid;
    end
  endgenerate
endmodule

// File: tb/conv_enc_tb.sv
module conv_enc_tb;
  // {input bit, first code bit, second code bit}; entries 0..7 are the R9 stream
  localparam logic [2:0] VEC [16] = '{
    3'b111, 3'b101, 3'b001, 3'b100, 3'b010, 3'b011, 3'b111, 3'b010,
    3'b011, 3'b111, 3'b010, 3'b011, 3'b111, 3'b101, 3'b110, 3'b110
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       v_par = 1'b0;
  logic       v_ser = 1'b0;
  logic       rdy_par, rdy_ser;
  logic [1:0] code_par, code_ser;
  logic       cv_par, cv_ser;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  conv_enc #(.SERIAL(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(v_par),
    .ready_o(rdy_par), .code_o(code_par), .code_valid_o(cv_par)
  );

  conv_enc #(.SERIAL(1'b1)) u_dut_ser (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(v_ser),
    .ready_o(rdy_ser), .code_o(code_ser), .code_valid_o(cv_ser)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // drives one bit into both instances over two cycles and checks every output
  task automatic send(input logic x, input logic c0, input logic c1, input string req);
    bit_i = x; v_par = 1'b1; v_ser = 1'b1;
    @(negedge clk);
    chk({req, " par valid R6"}, {1'b0, cv_par}, 2'b01);
    chk({req, " par pair"}, code_par, {c0, c1});
    chk({req, " ser first R7"}, {cv_ser, code_ser[0]}, {1'b1, c0});
    chk({req, " ser upper R7"}, {1'b0, code_ser[1]}, 2'b00);
    chk({req, " ser busy R8"}, {1'b0, rdy_ser}, 2'b00);
    v_par = 1'b0; bit_i = ~x;  // serial offer during hold-off must be ignored (R8)
    @(negedge clk);
    chk({req, " par idle R5"}, {1'b0, cv_par}, 2'b00);
    chk({req, " ser second R7"}, {cv_ser, code_ser[0]}, {1'b1, c1});
    chk({req, " ser ready R8"}, {1'b0, rdy_ser}, 2'b01);
    v_ser = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {cv_par, cv_ser}, 2'b00);
    chk("R1 ready in reset R6", {rdy_par, rdy_ser}, 2'b11);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {cv_par, cv_ser}, 2'b00);

    // table walk: R9 stream then further states (R2 R3 R4)
    for (int i = 0; i < 16; i++) begin
      send(VEC[i][2], VEC[i][1], VEC[i][0], (i < 8) ? "R9" : "R2 R3 R4");
    end

    @(negedge clk);
    chk("R5 no output when idle", {cv_par, cv_ser}, 2'b00);

    // state is 11 here; reset must clear it (from 11, input 1 would give 10)
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    send(1'b1, 1'b1, 1'b1, "R10 R1");

    // state is 10; toggling bit_i without valid must leave it alone
    for (int k = 0; k < 5; k++) begin
      bit_i = k[0];
      @(negedge clk);
      chk("R5 idle gap", {cv_par, cv_ser}, 2'b00);
    end
    send(1'b1, 1'b0, 1'b1, "R5 R4");
    send(1'b0, 1'b0, 1'b1, "R2 R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule